// File: doc/BRIEF.md
# Source Capability Object Assembler

This block keeps a table of up to seven 32-bit source power data objects and a header word that holds the count of valid objects. A host writes the table one word at a time. A reload pulse builds the list that goes out to the sink. The list is edited as it is built:

- Only the first N objects are kept.
- The two dual-role flags of the first object are forced from the port's swap enables.
- The current field of every fixed or variable object is limited to what the attached cable can carry.

The edited list is latched in one cycle. It then streams out one byte per accepted cycle on a valid/ready interface, each object least significant byte first. A single-cycle done pulse marks the end of the list.

The latched list is separate from the writable table. The host can rewrite the table while a list is streaming, and nothing changes on the wire until the next reload. The swap enables and the cable limit are sampled only in the reload cycle.

Top module: `scap_assembler`

## Requirements
- R1: A reload accepted while idle latches the edited list. From the next cycle, objects 1..N stream in order, each as four bytes, least significant byte first.
- R2: A write with `tbl_sel` = 0 sets the count N from `tbl_wdata[2:0]`. Writes with `tbl_sel` = 1..7 store objects 1..7. Objects beyond N are never sent, and exactly 4*N bytes go out.
- R3: With N = 0, no byte is offered and `done` pulses in the cycle right after the reload.
- R4: Bit 29 of the emitted first object equals the OR of the four `pr_swap_en` bits.
- R5: Bit 25 of the emitted first object equals the OR of the four `dr_swap_en` bits.
- R6: The first object is always handled as fixed supply. Its bits 31:30 go out as 00, and its bits 9:0 are clamped to `cable_ilim`, whatever type was stored.
- R7: For objects 2..N whose bits 31:30 are 00 (fixed) or 01 (variable), bits 9:0 go out as the minimum of the stored value and `cable_ilim`. All other bits are unchanged.
- R8: Objects 2..N whose bits 31:30 are 10 (battery) or 11 go out unchanged.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. Each cycle with both high moves to the next byte.
- R10: `done` is a one-cycle pulse in the cycle after the last byte is accepted. In that same cycle `busy` and `tx_valid` are low.
- R11: While streaming, reloads are ignored, and table writes, swap enables and cable limit changes do not alter the bytes in flight. Table changes appear only after a later reload.
- R12: An asynchronous low on `rst_n` clears `busy`, `tx_valid` and `done` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 3 | Word select: 0 header, 1..7 object |
| tbl_wdata | input | 32 | Table write data |
| pr_swap_en | input | 4 | Power-role swap enables |
| dr_swap_en | input | 4 | Data-role swap enables |
| cable_ilim | input | 10 | Cable current limit, same units as bits 9:0 |
| reload | input | 1 | Build and send the list |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Output byte |
| busy | output | 1 | List streaming |
| done | output | 1 | End-of-list pulse |

## Verification
The first byte is due one clock after the edge that takes the reload, because the list is latched on that edge. Each later byte is due one clock after the edge where the previous byte was accepted. `done` follows one clock after the last accepted byte; with an empty list it comes one clock after the reload. The bench drives `tx_ready` and `reload` on falling edges and reads the outputs on the same falling edges. A byte counts as transferred only when valid and ready are both seen before the rising edge, so every comparison lands in the cycle the outputs are due.

// File: rtl/scap_pkg.sv
package scap_pkg;
  localparam int OBJ_W = 32;
  localparam int BYTES_PER_OBJ = OBJ_W / 8;
  localparam int TYPE_HI = 31;
  localparam int TYPE_LO = 30;
  localparam int DRP_BIT = 29;
  localparam int DRD_BIT = 25;

  typedef enum logic [1:0] {
    SUP_FIXED = 2'b00,
    SUP_VAR   = 2'b01,
    SUP_BATT  = 2'b10,
    SUP_OTHER = 2'b11
  } sup_e;

  typedef logic [OBJ_W-1:0] obj_t;
endpackage

// File: rtl/scap_table.sv
module scap_table
  import scap_pkg::*;
#(
  parameter int NUM_OBJ = 7,
  parameter int CNT_W   = 3,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  obj_t             wdata,
  output logic [CNT_W-1:0] hdr_cnt,
  output obj_t             objs [NUM_OBJ]
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (we && sel == '0) cnt_q <= wdata[CNT_W-1:0];
  end

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_slot
    obj_t slot_q;
    logic slot_en;
    assign slot_en = we && (sel == SEL_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (slot_en) slot_q <= wdata;
    end
    assign objs[i] = slot_q;
  end

  assign hdr_cnt = cnt_q;
endmodule

// File: rtl/scap_edit.sv
module scap_edit
  import scap_pkg::*;
#(
  parameter int NUM_OBJ = 7,
  parameter int ILIM_W  = 10,
  parameter int SWAP_N  = 4
) (
  input  obj_t              objs_in [NUM_OBJ],
  input  logic [SWAP_N-1:0] pr_en,
  input  logic [SWAP_N-1:0] dr_en,
  input  logic [ILIM_W-1:0] ilim,
  output obj_t              objs_out [NUM_OBJ]
);
  logic drp, drd;
  assign drp = |pr_en;
  assign drd = |dr_en;

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    logic [ILIM_W-1:0] cur, cur_lim;
    assign cur     = objs_in[i][ILIM_W-1:0];
    assign cur_lim = (cur > ilim) ? ilim : cur;

    if (i == 0) begin : g_first
      always_comb begin
        objs_out[i] = objs_in[i];
        objs_out[i][TYPE_HI:TYPE_LO] = SUP_FIXED;
        objs_out[i][DRP_BIT] = drp;
        objs_out[i][DRD_BIT] = drd;
        objs_out[i][ILIM_W-1:0] = cur_lim;
      end
    end else begin : g_rest
      sup_e kind;
      assign kind = sup_e'(objs_in[i][TYPE_HI:TYPE_LO]);
      always_comb begin
        objs_out[i] = objs_in[i];
        if (kind == SUP_FIXED || kind == SUP_VAR)
          objs_out[i][ILIM_W-1:0] = cur_lim;
      end
    end
  end
endmodule

// File: rtl/scap_stream.sv
module scap_stream
  import scap_pkg::*;
#(
  parameter int NUM_OBJ = 7,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] hdr_cnt,
  input  obj_t             objs [NUM_OBJ],
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             busy,
  output logic             done
);
  localparam int BI_W = $clog2(BYTES_PER_OBJ);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_OBJ);
  localparam logic [BI_W-1:0] LAST_B = BI_W'(BYTES_PER_OBJ - 1);

  logic             busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0] num_q, num_d, oidx_q, oidx_d;
  logic [BI_W-1:0]  bidx_q, bidx_d;
  obj_t             lat_q [NUM_OBJ];
  obj_t             cur_word;
  logic [CNT_W-1:0] cnt_sat;
  logic             accept, fire, last;

  always_comb begin
    cnt_sat = (hdr_cnt > MAX_CNT) ? MAX_CNT : hdr_cnt;
    accept  = load && !busy_q;
    fire    = busy_q && tx_ready;
    last    = (oidx_q + 1'b1 == num_q) && (bidx_q == LAST_B);
    busy_d  = busy_q;
    done_d  = 1'b0;
    num_d   = num_q;
    oidx_d  = oidx_q;
    bidx_d  = bidx_q;
    if (accept) begin
      busy_d = (cnt_sat != '0);
      done_d = (cnt_sat == '0);
      num_d  = cnt_sat;
      oidx_d = '0;
      bidx_d = '0;
    end else if (fire) begin
      bidx_d = bidx_q + 1'b1;
      if (bidx_q == LAST_B) oidx_d = oidx_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      num_q  <= '0;
      oidx_q <= '0;
      bidx_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      num_q  <= num_d;
      oidx_q <= oidx_d;
      bidx_q <= bidx_d;
    end
  end

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= '0;
      else if (accept) lat_q[i] <= objs[i];
    end
  end

  always_comb begin
    cur_word = '0;
    for (int k = 0; k < NUM_OBJ; k++)
      if (oidx_q == CNT_W'(k)) cur_word = lat_q[k];
  end

  assign tx_data  = cur_word[{bidx_q, 3'b000} +: 8];
  assign tx_valid = busy_q;
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

// File: rtl/scap_assembler.sv
module scap_assembler
  import scap_pkg::*;
#(
  parameter int NUM_OBJ = 7,
  parameter int CNT_W   = 3,
  parameter int ILIM_W  = 10,
  parameter int SWAP_N  = 4,
  localparam int SEL_W  = $clog2(NUM_OBJ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [SEL_W-1:0]  tbl_sel,
  input  logic [31:0]       tbl_wdata,
  input  logic [SWAP_N-1:0] pr_swap_en,
  input  logic [SWAP_N-1:0] dr_swap_en,
  input  logic [ILIM_W-1:0] cable_ilim,
  input  logic              reload,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              busy,
  output logic              done
);
  logic [CNT_W-1:0] hdr_cnt;
  obj_t             raw_objs [NUM_OBJ];
  obj_t             ed_objs  [NUM_OBJ];

  scap_table #(.NUM_OBJ(NUM_OBJ), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tbl_we),
    .sel     (tbl_sel),
    .wdata   (tbl_wdata),
    .hdr_cnt (hdr_cnt),
    .objs    (raw_objs)
  );

  scap_edit #(.NUM_OBJ(NUM_OBJ), .ILIM_W(ILIM_W), .SWAP_N(SWAP_N)) u_edit (
    .objs_in  (raw_objs),
    .pr_en    (pr_swap_en),
    .dr_en    (dr_swap_en),
    .ilim     (cable_ilim),
    .objs_out (ed_objs)
  );

  scap_stream #(.NUM_OBJ(NUM_OBJ), .CNT_W(CNT_W)) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .hdr_cnt  (hdr_cnt),
    .objs     (ed_objs),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/scap_assembler_chk.sv
module scap_assembler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reload,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       busy,
  input logic       done
);
  // R9: a byte offered but not taken stays on the bus
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R10: done lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: no byte offered while done is high
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tx_valid));

  // R10: the end of a stream is always marked by done
  a_r10_end_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R1: a stream only starts from a reload
  a_r1_start_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reload));
endmodule

bind scap_assembler scap_assembler_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reload   (reload),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_scap_assembler.sv
module sim_scap_assembler;
  logic        clk, rst_n, tbl_we, reload, tx_ready;
  logic [2:0]  tbl_sel;
  logic [31:0] tbl_wdata;
  logic [3:0]  pr_swap_en, dr_swap_en;
  logic [9:0]  cable_ilim;
  logic        tx_valid, busy, done;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] ew [7];

  scap_assembler u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_wdata(tbl_wdata), .pr_swap_en(pr_swap_en), .dr_swap_en(dr_swap_en),
    .cable_ilim(cable_ilim), .reload(reload), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  cnt;
    logic [31:0] w1, w2, w3;
    logic [9:0]  ilim;
    logic [3:0]  pr, dr;
    logic [1:0]  mode;
    logic [5:0]  exp_bytes;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'hC300_0190, 32'h0001_2345, 32'h4000_0000, 10'd100, 4'b0000, 4'b0000, 2'd0, 6'd4},
    '{3'd3, 32'h0001_9064, 32'h4643_20C8, 32'h8FFF_FFFF, 10'd150, 4'b0100, 4'b0000, 2'd1, 6'd12},
    '{3'd7, 32'h2201_912C, 32'h0002_D3FF, 32'hC123_4FFF, 10'h3FF, 4'b0000, 4'b0001, 2'd2, 6'd28},
    '{3'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 10'd0,   4'b0010, 4'b0010, 2'd0, 6'd8},
    '{3'd5, 32'h0A01_9032, 32'h0002_D010, 32'h8000_03FF, 10'd500, 4'b0001, 4'b0100, 2'd1, 6'd20},
    '{3'd4, 32'h0001_90FA, 32'h4000_03E8, 32'h0000_0001, 10'd1,   4'b1000, 4'b1000, 2'd2, 6'd16}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_word(input vec_t v, input int i);
    if (i == 0) return v.w1;
    if (i == 1) return v.w2;
    if (i == 2) return v.w3;
    return v.w2 ^ (32'(i) * 32'h0101_0101);
  endfunction

  // Independent model of the requirements (R4..R8)
  function automatic logic [31:0] model(input logic [31:0] w, input int i,
                                        input logic [9:0] lim, input logic [3:0] pr,
                                        input logic [3:0] dr);
    logic [31:0] r;
    r = w;
    if (i == 0) begin
      r[31:30] = 2'b00;
      r[29] = |pr;
      r[25] = |dr;
      if (r[9:0] > lim) r[9:0] = lim;
    end else if (w[31:30] == 2'b00 || w[31:30] == 2'b01) begin
      if (r[9:0] > lim) r[9:0] = lim;
    end
    return r;
  endfunction

  function automatic bit rdy(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 2;
      default: return (cyc % 2) == 0;
    endcase
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Pulse reload and collect bytes; poke injects R11 disturbances mid-stream
  task automatic run_stream(input int n, input int mode, input bit poke, input string tag);
    int nb = 0;
    int done_cyc = 0;
    bit got_done = 0;
    logic [7:0] eb;
    @(negedge clk);
    reload = 1'b1;
    tx_ready = rdy(mode, 0);
    for (int cyc = 1; cyc < 600 && !got_done; cyc++) begin
      @(negedge clk);
      reload = 1'b0;
      tbl_we = 1'b0;
      if (done) begin
        got_done = 1;
        done_cyc = cyc;
        chk(!busy && !tx_valid, {"R10 idle at done ", tag}, {30'd0, busy, tx_valid}, 32'd0);
      end else if (tx_valid && tx_ready) begin
        if (nb < 4 * n) begin
          eb = 8'(ew[nb / 4] >> (8 * (nb % 4)));
          if (nb < 4)
            chk(tx_data == eb, {"R1 R4 R5 R6 first object byte ", tag}, 32'(tx_data), 32'(eb));
          else
            chk(tx_data == eb, {"R1 R7 R8 R11 object byte ", tag}, 32'(tx_data), 32'(eb));
        end else begin
          chk(1'b0, {"R2 extra byte ", tag}, 32'(nb), 32'(4 * n));
        end
        nb++;
      end
      if (poke && cyc == 3) begin
        tbl_we = 1'b1; tbl_sel = 3'd1; tbl_wdata = 32'h0000_0055;
        reload = 1'b1; cable_ilim = 10'd0; pr_swap_en = 4'hF;
      end
      tx_ready = rdy(mode, cyc);
    end
    chk(got_done, {"R10 done seen ", tag}, 32'(got_done), 32'd1);
    chk(nb == 4 * n, {"R2 byte count ", tag}, 32'(nb), 32'(4 * n));
    if (n == 0) chk(done_cyc == 1, {"R3 done timing ", tag}, 32'(done_cyc), 32'd1);
    @(negedge clk);
    chk(!tx_valid && !done, {"R10 R11 quiet after done ", tag}, {30'd0, tx_valid, done}, 32'd0);
  endtask

  task automatic load_vec(input vec_t v);
    wr(3'd0, {29'd0, v.cnt});
    for (int i = 0; i < 7; i++) wr(3'(i + 1), slot_word(v, i));
    cable_ilim = v.ilim; pr_swap_en = v.pr; dr_swap_en = v.dr;
    for (int i = 0; i < 7; i++) ew[i] = model(slot_word(v, i), i, v.ilim, v.pr, v.dr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t d;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_sel = '0; tbl_wdata = '0; reload = 1'b0;
    tx_ready = 1'b0; pr_swap_en = '0; dr_swap_en = '0; cable_ilim = '0;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !done, "R12 reset state", {29'd0, tx_valid, busy, done}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      load_vec(VECS[k]);
      run_stream(int'(VECS[k].cnt), int'(VECS[k].mode), 1'b0, $sformatf("vec%0d", k));
      chk(int'(VECS[k].exp_bytes) == 4 * int'(VECS[k].cnt), "R2 vector table", 32'(VECS[k].exp_bytes), 32'(4 * VECS[k].cnt));
    end

    // R3: empty list
    d = VECS[1]; d.cnt = 3'd0;
    load_vec(d);
    run_stream(0, 0, 1'b0, "empty");

    // R11: disturbances during a stream are ignored; the table change shows after reload
    d = VECS[2]; d.cnt = 3'd2;
    load_vec(d);
    run_stream(2, 1, 1'b1, "poke");
    for (int i = 0; i < 7; i++) ew[i] = model(i == 0 ? 32'h0000_0055 : slot_word(d, i), i, 10'd0, 4'hF, d.dr);
    run_stream(2, 0, 1'b0, "after poke");

    // R12: asynchronous reset in mid-stream
    load_vec(VECS[2]);
    @(negedge clk); reload = 1'b1; tx_ready = 1'b0;
    @(negedge clk); reload = 1'b0;
    chk(busy && tx_valid, "R1 stream started", {30'd0, busy, tx_valid}, 32'd3);
    #3 rst_n = 1'b0;
    #1 chk(!tx_valid && !busy && !done, "R12 async clear", {29'd0, tx_valid, busy, done}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid, "R12 stays idle", 32'(tx_valid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule